// File: doc/BRIEF.md
# PC Card Byte Lane Steering

This block sits between a 16-bit host data bus and a card built from pairs of byte-wide memory segments. Each pair holds an even segment, which carries the low byte of every word, and an odd segment, which carries the high byte.

From the active-low card enables, the register-space select, the output and write strobes, address bit 0 and the segment-pair address bits, the block works out four things:
- which segment chip enables to raise;
- whether the access goes to the separate attribute memory;
- which data lanes the card drives during a read;
- whether the odd byte must be routed onto the low lane.

It also produces the internal active-low write strobe, which is gated by a write-protect switch and blocked when the output and write strobes are both active. In the attribute space only even bytes exist, so any lane that would carry an odd byte on a read is flagged invalid. In the common space a pair address beyond the populated pairs selects no segment, and the active lanes are flagged to return all ones.

All outputs are registered. They reflect the inputs sampled at one rising clock edge immediately after that edge.

Top module: `pccard_lane_steer`

## Requirements
- R1: While reset is asserted, every output is inactive: no chip enable, no lane enable, no swap, no flag, and `wr_n` high. After reset, the outputs show the inputs sampled at the previous rising edge.
- R2: With `ce1_n`=0, `ce2_n`=1 and `a0`=0, only the even segment of the addressed pair is enabled. During a read only the low lane is driven, and `swap`=0.
- R3: With `ce1_n`=0, `ce2_n`=1 and `a0`=1, only the odd segment is enabled and `swap`=1, routing the high byte onto the low lane. During a read only the low lane is driven.
- R4: With `ce1_n`=1 and `ce2_n`=0, only the odd segment is enabled whatever `a0` is. During a read only the high lane is driven, and `swap`=0.
- R5: With both enables low, both segments of the pair are enabled, both lanes are driven on a read, `swap`=0, and `a0` has no effect.
- R6: A read is `oe_n`=0 with `we_n`=1. With `oe_n` high, or with both enables high, neither lane is driven. With both enables high, no chip enable and no attribute select is raised.
- R7: With `reg_n`=0, no segment chip enable is raised. `attr_ce` is raised exactly when the even byte is reached (the R2 or R5 pattern), so odd-only writes have no effect on the attribute memory.
- R8: During an attribute read, `lo_bad` is set when the low lane carries the odd byte (the R3 pattern), and `hi_bad` is set whenever the high lane is driven.
- R9: `wr_n` goes low only when all of these hold: `we_n`=0, `oe_n`=1, at least one enable low, and `wp_sw`=0. An active write-protect switch always keeps `wr_n` high.
- R10: If `we_n` and `oe_n` are both low, no write is issued and no lane is driven.
- R11: Segment pair k is selected by `seg_addr`=k, each pair spanning 80000h bytes of common space. At most one pair's even enable and one pair's odd enable are active at a time.
- R12: A common-space read with `seg_addr` at or above PAIRS enables no segment, and it sets `lo_ones`/`hi_ones` on exactly the lanes that are driven, so those lanes return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Low-lane card enable, active low |
| ce2_n | input | 1 | High-lane card enable, active low |
| reg_n | input | 1 | Attribute-space select, active low |
| oe_n | input | 1 | Output strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Byte address bit 0 |
| seg_addr | input | SEL_W | Segment pair address (upper address bits) |
| wp_sw | input | 1 | Write-protect switch, active high |
| ev_ce | output | PAIRS | Even segment chip enables, one per pair |
| od_ce | output | PAIRS | Odd segment chip enables, one per pair |
| attr_ce | output | 1 | Attribute memory select |
| lo_oe | output | 1 | Drive data bits 7:0 |
| hi_oe | output | 1 | Drive data bits 15:8 |
| swap | output | 1 | Route odd byte onto the low lane |
| lo_bad | output | 1 | Low lane carries invalid attribute data |
| hi_bad | output | 1 | High lane carries invalid attribute data |
| lo_ones | output | 1 | Low lane returns FFh (unpopulated pair) |
| hi_ones | output | 1 | High lane returns FFh (unpopulated pair) |
| wr_n | output | 1 | Internal write strobe, active low |

## Verification
The bench sweeps every combination of the strobes, enables, `a0`, the protect switch and all four pair addresses, with two of the four pairs populated. For each combination it derives the expected outputs arithmetically.

The corner cases it targets are these:
- **Odd byte in x8 mode with `a0` high.** A design that forgot the transposition would leave the low lane carrying the even byte.
- **High-only access with `a0` high.** A design that let `a0` leak into this case would wrongly set `swap` or enable the even segment.
- **Odd-only attribute writes.** A careless design would raise `attr_ce` and corrupt the attribute memory.
- **Both strobes low, and write-protect on.** A wrong design would let a write through or drive the bus into a write.
- **Unpopulated pair addresses.** A wrong design would alias onto a real pair instead of returning all ones.

// File: rtl/pccard_steer_pkg.sv
package pccard_steer_pkg;

    // Registered lane and strobe controls shared by the decoder and the top.
    typedef struct packed {
        logic attr_ce;
        logic lo_oe;
        logic hi_oe;
        logic swap;
        logic lo_bad;
        logic hi_bad;
        logic lo_ones;
        logic hi_ones;
        logic wr_n;
    } lane_ctl_t;

    localparam lane_ctl_t LANE_IDLE = '{
        attr_ce: 1'b0,
        lo_oe:   1'b0,
        hi_oe:   1'b0,
        swap:    1'b0,
        lo_bad:  1'b0,
        hi_bad:  1'b0,
        lo_ones: 1'b0,
        hi_ones: 1'b0,
        wr_n:    1'b1
    };

endpackage

// File: rtl/pccard_lane_decode.sv
module pccard_lane_decode
    import pccard_steer_pkg::*;
(
    input  logic      ce1_n,
    input  logic      ce2_n,
    input  logic      reg_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      a0,
    input  logic      wp_sw,
    input  logic      populated,
    output logic      even_acc,
    output logic      odd_acc,
    output lane_ctl_t ctl
);

    logic lo_used;
    logic hi_used;
    logic lo_only;
    logic rd;
    logic wr;
    logic attr;

    always_comb begin
        lo_used  = ~ce1_n;
        hi_used  = ~ce2_n;
        lo_only  = lo_used & ~hi_used;
        attr     = ~reg_n;

        // Even byte reached by a word access or an x8 access with a0 low.
        even_acc = lo_used & (hi_used | ~a0);
        // Odd byte reached on the high lane, or transposed in x8 mode.
        odd_acc  = hi_used | (lo_only & a0);

        // A read needs OE without WE; a write needs WE without OE.
        rd = ~oe_n & we_n;
        wr = ~we_n & oe_n & ~wp_sw & (lo_used | hi_used);

        ctl.attr_ce = attr & even_acc;
        ctl.lo_oe   = rd & lo_used;
        ctl.hi_oe   = rd & hi_used;
        ctl.swap    = lo_only & a0;
        ctl.lo_bad  = rd & attr & lo_only & a0;
        ctl.hi_bad  = rd & attr & hi_used;
        ctl.lo_ones = rd & ~attr & ~populated & lo_used;
        ctl.hi_ones = rd & ~attr & ~populated & hi_used;
        ctl.wr_n    = ~wr;
    end

endmodule

// File: rtl/pccard_seg_select.sv
module pccard_seg_select #(
    parameter int PAIRS = 2,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] seg_addr,
    input  logic             common,
    input  logic             even_acc,
    input  logic             odd_acc,
    output logic             populated,
    output logic [PAIRS-1:0] ev_ce,
    output logic [PAIRS-1:0] od_ce
);

    localparam logic [SEL_W:0] POP_LIMIT = (SEL_W + 1)'(PAIRS);

    always_comb populated = ({1'b0, seg_addr} < POP_LIMIT);

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        logic hit;
        always_comb begin
            hit      = common & (seg_addr == SEL_W'(g));
            ev_ce[g] = hit & even_acc;
            od_ce[g] = hit & odd_acc;
        end
    end

endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
    import pccard_steer_pkg::*;
#(
    parameter int PAIRS = 2,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce1_n,
    input  logic             ce2_n,
    input  logic             reg_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             a0,
    input  logic [SEL_W-1:0] seg_addr,
    input  logic             wp_sw,
    output logic [PAIRS-1:0] ev_ce,
    output logic [PAIRS-1:0] od_ce,
    output logic             attr_ce,
    output logic             lo_oe,
    output logic             hi_oe,
    output logic             swap,
    output logic             lo_bad,
    output logic             hi_bad,
    output logic             lo_ones,
    output logic             hi_ones,
    output logic             wr_n
);

    logic             even_acc;
    logic             odd_acc;
    logic             populated;
    lane_ctl_t        ctl_c;
    logic [PAIRS-1:0] ev_c;
    logic [PAIRS-1:0] od_c;

    lane_ctl_t        ctl_d, ctl_q;
    logic [PAIRS-1:0] ev_d, ev_q;
    logic [PAIRS-1:0] od_d, od_q;

    pccard_lane_decode u_lane (
        .ce1_n     (ce1_n),
        .ce2_n     (ce2_n),
        .reg_n     (reg_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .a0        (a0),
        .wp_sw     (wp_sw),
        .populated (populated),
        .even_acc  (even_acc),
        .odd_acc   (odd_acc),
        .ctl       (ctl_c)
    );

    pccard_seg_select #(.PAIRS(PAIRS), .SEL_W(SEL_W)) u_seg (
        .seg_addr  (seg_addr),
        .common    (reg_n),
        .even_acc  (even_acc),
        .odd_acc   (odd_acc),
        .populated (populated),
        .ev_ce     (ev_c),
        .od_ce     (od_c)
    );

    always_comb begin
        ctl_d = ctl_c;
        ev_d  = ev_c;
        od_d  = od_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= LANE_IDLE;
            ev_q  <= '0;
            od_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            ev_q  <= ev_d;
            od_q  <= od_d;
        end
    end

    assign ev_ce   = ev_q;
    assign od_ce   = od_q;
    assign attr_ce = ctl_q.attr_ce;
    assign lo_oe   = ctl_q.lo_oe;
    assign hi_oe   = ctl_q.hi_oe;
    assign swap    = ctl_q.swap;
    assign lo_bad  = ctl_q.lo_bad;
    assign hi_bad  = ctl_q.hi_bad;
    assign lo_ones = ctl_q.lo_ones;
    assign hi_ones = ctl_q.hi_ones;
    assign wr_n    = ctl_q.wr_n;

    a_r3_odd_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !ce1_n && ce2_n && a0 && !oe_n && we_n
        |=> swap && lo_oe && !hi_oe);

    a_r6_float_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && oe_n |=> !lo_oe && !hi_oe);

    a_r7_attr_no_segment: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !reg_n |=> (ev_ce == '0) && (od_ce == '0));

    a_r9_protect_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && wp_sw |=> wr_n);

    a_r10_strobe_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !oe_n && !we_n |=> wr_n && !lo_oe && !hi_oe);

    a_r11_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_ce) && $onehot0(od_ce));

    a_r12_ones_only_common: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_ones || hi_ones) |-> !attr_ce && (ev_ce == '0) && (od_ce == '0));

endmodule

// File: tb/pccard_lane_steer_tb.sv
`timescale 1ns/1ps
module pccard_lane_steer_tb;

    localparam int PAIRS = 2;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ce1_n, ce2_n, reg_n, oe_n, we_n, a0, wp_sw;
    logic [SEL_W-1:0] seg_addr;
    logic [PAIRS-1:0] ev_ce, od_ce;
    logic             attr_ce, lo_oe, hi_oe, swap, lo_bad, hi_bad;
    logic             lo_ones, hi_ones, wr_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pccard_lane_steer #(.PAIRS(PAIRS), .SEL_W(SEL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
        .oe_n(oe_n), .we_n(we_n), .a0(a0), .seg_addr(seg_addr), .wp_sw(wp_sw),
        .ev_ce(ev_ce), .od_ce(od_ce), .attr_ce(attr_ce), .lo_oe(lo_oe),
        .hi_oe(hi_oe), .swap(swap), .lo_bad(lo_bad), .hi_bad(hi_bad),
        .lo_ones(lo_ones), .hi_ones(hi_ones), .wr_n(wr_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (ce1_n=%b ce2_n=%b reg_n=%b oe_n=%b we_n=%b a0=%b wp=%b seg=%0d)",
                     req, what, act, exp, ce1_n, ce2_n, reg_n, oe_n, we_n, a0, wp_sw, seg_addr);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ce1_n = 1'b0; ce2_n = 1'b0; reg_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        a0 = 1'b0; wp_sw = 1'b0; seg_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset holds every output inactive despite an active read on the pins
        chk("R1", "ev_ce", 8'(ev_ce), 8'h0);
        chk("R1", "od_ce", 8'(od_ce), 8'h0);
        chk("R1", "lanes", {4'h0, attr_ce, lo_oe, hi_oe, swap}, 8'h0);
        chk("R1", "flags", {4'h0, lo_bad, hi_bad, lo_ones, hi_ones}, 8'h0);
        chk("R1", "wr_n", 8'(wr_n), 8'h1);
        rst_n = 1'b1;

        for (int v = 0; v < 512; v++) begin
            logic lo_used, hi_used, even, odd, sw, rd, pop;
            logic [7:0] exp_ev, exp_od;
            @(negedge clk);
            ce1_n = v[0]; ce2_n = v[1]; reg_n = v[2]; oe_n = v[3];
            we_n = v[4]; a0 = v[5]; wp_sw = v[6]; seg_addr = SEL_W'(v >> 7);

            lo_used = 1'b0; hi_used = 1'b0; even = 1'b0; odd = 1'b0; sw = 1'b0;
            case ({ce1_n, ce2_n})
                2'b01: begin
                    lo_used = 1'b1;
                    if (a0) begin odd = 1'b1; sw = 1'b1; end
                    else    even = 1'b1;
                end
                2'b10: begin hi_used = 1'b1; odd = 1'b1; end
                2'b00: begin lo_used = 1'b1; hi_used = 1'b1; even = 1'b1; odd = 1'b1; end
                default: ;
            endcase
            rd  = !oe_n && we_n;
            pop = (int'(seg_addr) < PAIRS);
            exp_ev = (reg_n && pop && even) ? 8'(1 << seg_addr) : 8'h0;
            exp_od = (reg_n && pop && odd)  ? 8'(1 << seg_addr) : 8'h0;

            @(negedge clk);
            // R2 R3 R4 R5 R11 R12: segment enables per lane pattern and pair address
            chk("R2/R3/R4/R5/R11", "ev_ce", 8'(ev_ce), exp_ev);
            chk("R3/R4/R5/R11", "od_ce", 8'(od_ce), exp_od);
            // R6 R10: lane drives only on a proper read
            chk("R6/R10", "lo_oe", 8'(lo_oe), 8'(rd && lo_used));
            chk("R6/R10", "hi_oe", 8'(hi_oe), 8'(rd && hi_used));
            // R3: transposition only for the x8 odd pattern
            chk("R3", "swap", 8'(swap), 8'(sw));
            // R7: attribute select only when the even byte is reached
            chk("R7", "attr_ce", 8'(attr_ce), 8'(!reg_n && even));
            // R8: invalid odd lanes in attribute reads
            chk("R8", "lo_bad", 8'(lo_bad), 8'(rd && !reg_n && sw));
            chk("R8", "hi_bad", 8'(hi_bad), 8'(rd && !reg_n && hi_used));
            // R12: unpopulated pairs return ones on driven lanes
            chk("R12", "lo_ones", 8'(lo_ones), 8'(rd && reg_n && !pop && lo_used));
            chk("R12", "hi_ones", 8'(hi_ones), 8'(rd && reg_n && !pop && hi_used));
            // R9 R10: write strobe gating
            chk("R9/R10", "wr_n", 8'(wr_n),
                8'(!(!we_n && oe_n && !wp_sw && (lo_used || hi_used))));
        end

        // R1: re-entering reset clears outputs on the next edge
        @(negedge clk);
        ce1_n = 1'b0; ce2_n = 1'b0; reg_n = 1'b1; oe_n = 1'b1; we_n = 1'b0;
        wp_sw = 1'b0; seg_addr = '0;
        @(negedge clk);
        chk("R9", "wr_n before reset", 8'(wr_n), 8'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "wr_n in reset", 8'(wr_n), 8'h1);
        chk("R1", "ev_ce in reset", 8'(ev_ce), 8'h0);

        summary();
        $finish;
    end

endmodule